// File: doc/BRIEF.md
# Pulse-Width Motor Command Transmitter

This block drives a single-wire command line to a motor speed controller. It takes an 11-bit throttle value and a one-bit telemetry request, both held by the processor. From these it builds a 16-bit command word that ends in a 4-bit checksum. It then sends the word bit by bit, with no further attention from the processor. Each bit lasts a fixed number of clock cycles. The value of a bit is carried only by how long the line stays high at the start of its slot: a short pulse is a 0 and a long pulse is a 1.

The transmitter repeats the word without end while `run` is high. It waits a fixed quiet gap between words, and the line is low whenever no bit is in progress. The inputs are sampled only at the instant a word begins, so the processor can change them at any time without tearing a word in flight. All timing is counted in cycles of a 100 MHz clock. The defaults give a 1.67 µs slot, a 0.62 µs or 1.25 µs high time, and a gap of just over 2 µs.

Top module: `motor_pulse_tx`

## Requirements
- R1: While `rst_n` is low, `line_out` is low. After reset is released, the line stays low for exactly GAP_CYC+1 cycles before the first word begins, counting the cycle in which reset is released.
- R2: The transmitted word holds the throttle in bits 15..5, the telemetry request in bit 4 and the checksum in bits 3..0. Bit 15 is sent first.
- R3: The checksum is the XOR of the three 4-bit nibbles of the 12-bit value {throttle, telemetry request}.
- R4: Every bit slot lasts exactly SLOT_CYC cycles (default 167). The high part of each slot starts at the slot's first cycle.
- R5: A 0 bit is high for exactly HI0_CYC cycles (default 62), and a 1 bit for exactly HI1_CYC cycles (default 125). The line is low for the rest of the slot.
- R6: After the last slot of a word, the line stays low for exactly GAP_CYC+1 cycles (default 201) before the next word, as long as `run` stays high.
- R7: While `run` is high, words follow one another without end, each built from the inputs current at its own start.
- R8: A change of `throttle` or `telem_req` after a word has begun has no effect on that word. It first appears in the next word.
- R9: When `run` is low, no new word begins, but a word already in progress is completed. When `run` rises after the gap has elapsed, a word begins on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, nominally 100 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Allows new words to begin |
| throttle | input | 11 | Throttle value to send |
| telem_req | input | 1 | Telemetry request flag to send |
| line_out | output | 1 | Pulse-coded command line, low when idle |

## Verification
The hardest case to reach is an input change that lands inside a word, after the start-of-word sample has been taken. From the ports, the only sign that the sample has been taken is the first rising edge of the line. The stimulus therefore waits for each rising edge and loads the next random or corner value straight after it. The decoded word must then show the old value, and the word after it the new one. The `run` gating is handled the same way: `run` is dropped just after a word starts, which shows that the word completes and that the line then stays quiet for a long stretch.

// File: rtl/motor_pulse_tx.sv
module motor_pulse_tx #(
  parameter int SLOT_CYC = 167,
  parameter int HI0_CYC  = 62,
  parameter int HI1_CYC  = 125,
  parameter int GAP_CYC  = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic [10:0] throttle,
  input  logic        telem_req,
  output logic        line_out
);
  localparam int NBITS = 16;
  localparam int CW    = $clog2(SLOT_CYC);
  localparam int GW    = $clog2(GAP_CYC + 1);
  localparam int BW    = $clog2(NBITS);

  logic [11:0]      payload;
  logic [3:0]       csum;
  logic [NBITS-1:0] word;
  logic             in_frame;
  logic [CW-1:0]    slot_cnt;
  logic [BW-1:0]    bit_idx;
  logic [NBITS-1:0] shreg;
  logic [GW-1:0]    gap_cnt;
  logic [CW-1:0]    hi_len;

  assign payload = {throttle, telem_req};
  assign csum    = payload[11:8] ^ payload[7:4] ^ payload[3:0];
  assign word    = {payload, csum};
  assign hi_len  = shreg[NBITS-1] ? CW'(HI1_CYC) : CW'(HI0_CYC);
  assign line_out = in_frame && (slot_cnt < hi_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      slot_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      gap_cnt  <= '0;
    end else if (!in_frame) begin
      if (gap_cnt == GW'(GAP_CYC) && run) begin
        in_frame <= 1'b1;
        shreg    <= word;
        slot_cnt <= '0;
        bit_idx  <= '0;
        gap_cnt  <= '0;
      end else if (gap_cnt != GW'(GAP_CYC)) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end else if (slot_cnt == CW'(SLOT_CYC - 1)) begin
      slot_cnt <= '0;
      shreg    <= {shreg[NBITS-2:0], 1'b0};
      if (bit_idx == BW'(NBITS - 1)) in_frame <= 1'b0;
      else bit_idx <= bit_idx + 1'b1;
    end else begin
      slot_cnt <= slot_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/motor_pulse_tx_chk.sv
module motor_pulse_tx_chk #(
  parameter int SLOT_CYC = 167,
  parameter int HI0_CYC  = 62,
  parameter int HI1_CYC  = 125,
  parameter int GAP_CYC  = 200,
  parameter int CW       = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          line_out,
  input logic          in_frame,
  input logic [CW-1:0] slot_cnt
);
  int unsigned hi_run;
  int unsigned lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= 0;
      lo_run <= 0;
    end else begin
      hi_run <= line_out ? hi_run + 1 : 0;
      lo_run <= line_out ? 0 : ((lo_run < 32'd1000000) ? lo_run + 1 : lo_run);
    end
  end

  assert_slot_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_cnt) < SLOT_CYC);

  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_out) |-> (hi_run == HI0_CYC || hi_run == HI1_CYC));

  assert_pulse_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_out |-> hi_run < HI1_CYC);

  assert_low_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_out) |-> (lo_run == SLOT_CYC - HI0_CYC || lo_run == SLOT_CYC - HI1_CYC
                         || lo_run >= GAP_CYC));

  assert_start_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(run));
endmodule

bind motor_pulse_tx motor_pulse_tx_chk #(
  .SLOT_CYC(SLOT_CYC), .HI0_CYC(HI0_CYC), .HI1_CYC(HI1_CYC),
  .GAP_CYC(GAP_CYC), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .line_out(line_out),
  .in_frame(in_frame), .slot_cnt(slot_cnt)
);

// File: tb/motor_pulse_tx_tb_top.sv
module motor_pulse_tx_tb_top;
  localparam int SLOT = 167, HI0 = 62, HI1 = 125, GAP = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b1;
  logic [10:0] throttle = '0;
  logic telem_req = 1'b0;
  logic line_out;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  motor_pulse_tx #(.SLOT_CYC(SLOT), .HI0_CYC(HI0), .HI1_CYC(HI1), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .throttle(throttle),
    .telem_req(telem_req), .line_out(line_out));

  function automatic logic [15:0] exp_word(input logic [10:0] t, input logic e);
    logic [11:0] v;
    v = {t, e};
    return {v, v[11:8] ^ v[7:4] ^ v[3:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Called at a negedge where line_out is high (first high cycle of a word).
  task automatic rx_word(output logic [15:0] w);
    int h, l;
    w = '0;
    for (int b = 0; b < 16; b++) begin
      h = 0;
      while (line_out && h < 1000) begin h++; @(negedge clk); end
      l = 0;
      if (b < 15) begin
        while (!line_out && l < 1000) begin l++; @(negedge clk); end
        if (h + l != SLOT) chk(0, "R4 slot length", h + l, SLOT);
      end else begin
        while (h + l < SLOT) begin
          if (line_out) chk(0, "R5 low tail of last slot", 1, 0);
          l++; @(negedge clk);
        end
      end
      if (h != HI0 && h != HI1) chk(0, "R5 high time", h, HI1);
      w = {w[14:0], (h == HI1)};
    end
  endtask

  task automatic measure_low(output int g);
    g = 0;
    while (!line_out && g < 5000) begin g++; @(negedge clk); end
  endtask

  initial begin
    logic [10:0] cur_t, nxt_t;
    logic cur_e, nxt_e;
    logic [15:0] w;
    int g;
    logic [10:0] dir_t [5];
    logic dir_e [5];
    void'($urandom(32'd4242));
    dir_t[0] = 11'h000; dir_e[0] = 1'b0;
    dir_t[1] = 11'h7FF; dir_e[1] = 1'b1;
    dir_t[2] = 11'h555; dir_e[2] = 1'b0;
    dir_t[3] = 11'h2AA; dir_e[3] = 1'b1;
    dir_t[4] = 11'h030; dir_e[4] = 1'b0;

    cur_t = 11'h123; cur_e = 1'b1;
    throttle = cur_t; telem_req = cur_e;
    repeat (5) @(negedge clk);
    chk(line_out == 1'b0, "R1 low in reset", int'(line_out), 0);
    rst_n = 1'b1;
    measure_low(g);
    chk(g == GAP + 1, "R1 first word delay", g, GAP + 1);

    for (int i = 0; i < 22; i++) begin
      if (i < 5) begin nxt_t = dir_t[i]; nxt_e = dir_e[i]; end
      else begin nxt_t = 11'($urandom); nxt_e = 1'($urandom); end
      throttle = nxt_t; telem_req = nxt_e;
      rx_word(w);
      chk(w == exp_word(cur_t, cur_e), "R2 R3 R8 R7 word content", int'(w),
          int'(exp_word(cur_t, cur_e)));
      cur_t = nxt_t; cur_e = nxt_e;
      measure_low(g);
      chk(g == GAP + 1, "R6 inter-word gap", g, GAP + 1);
    end

    run = 1'b0;
    nxt_t = 11'h4C1; nxt_e = 1'b1;
    throttle = nxt_t; telem_req = nxt_e;
    rx_word(w);
    chk(w == exp_word(cur_t, cur_e), "R9 word in flight completes", int'(w),
        int'(exp_word(cur_t, cur_e)));
    cur_t = nxt_t; cur_e = nxt_e;
    measure_low(g);
    chk(g == 5000, "R9 no word while run low", g, 5000);
    run = 1'b1;
    @(negedge clk);
    chk(line_out == 1'b1, "R9 start on run rise", int'(line_out), 1);
    rx_word(w);
    chk(w == exp_word(cur_t, cur_e), "R9 R8 word after resume", int'(w),
        int'(exp_word(cur_t, cur_e)));

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end
endmodule